// File: doc/BRIEF.md
# Multi-Link Event Sequencer

This block sequences events through a pattern-recognition stage built from twelve hit input queues, four matching engines that work side by side, and sixteen road output links. Once an event is open, the block reads the heads of every hit queue in lockstep. It presents them as a single wide beat on a broadcast bus that all engines share. A beat moves only when every engine is ready, so each engine sees the same sequence of hits. Each hit lane closes after its end-of-event word has been read. Any later words in that queue belong to the next event and wait there.

On the output side, each road link is a pass-through stream from an engine to a downstream buffer. A downstream buffer that reaches half full raises a hold for its own link. While the hold is up, that link does not move, and no road is lost or repeated. A link closes after it has delivered its end-of-event word. The event completes only when every hit lane and every road link has closed. A one-cycle completion pulse then fires, the event counter steps, and both close masks clear. The next event opens from idle once every hit queue reports that it holds a buffered end-of-event word. Those words can pile up while the previous event is still draining.

Back-pressure rules: on a hit lane, a word is consumed in a cycle where `in_valid` and `in_ready` are both high. On the broadcast bus, a beat transfers when `bc_valid` is high and every bit of `eng_ready` is high. `bc_valid` never depends on `eng_ready`. On a road link, a word is consumed from the engine when `rin_valid` and `rin_ready` are both high. It is delivered downstream in that same cycle on `rout_valid`, which has no ready signal; `hold` is that link's only back-pressure.

Top module: `evt_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `evt_busy`, `evt_done`, `bc_valid`, every `in_ready` and every `rin_ready` are low, and `evt_count` is 0.
- R2: An event opens (`evt_busy` rises) only on the clock after a cycle in which every `fifo_has_eoe` bit was high. While any bit is low the block stays idle.
- R3: While an event is open, `bc_valid` is high exactly when every still-open lane has `in_valid` high and at least one lane is open. Lane i occupies `bc_data[16*i +: 16]`, and `bc_lane[i]` marks the lane as open. An event produces as many beats as its longest lane has words, counting the end-of-event word.
- R4: A hit word is consumed on any lane only in a cycle where `bc_valid` is high and every `eng_ready` bit is high. If one engine deasserts ready, all lanes stall.
- R5: After lane i delivers a word with `in_eoe` high, `in_ready[i]` stays low for the rest of the event, even if the queue already holds words for the next event.
- R6: A road word is delivered (`rout_valid[l]` high, `rout_data` slice l equal to the engine's word) only in a cycle where it is consumed from that engine. Words on a link arrive in order, with none dropped and none repeated.
- R7: While `hold[l]` is high, both `rout_valid[l]` and `rin_ready[l]` are low. The pending word is delivered once after the hold drops.
- R8: After road link l delivers a word with `rin_eoe` high, the link accepts no more words until the next event opens.
- R9: `evt_done` pulses high for one cycle only after every hit lane and every road link has delivered its end-of-event word. `evt_count` shows the incremented value in that same cycle.
- R10: Both close masks clear on the clock after the completion pulse, so the following event reads every lane and every link again.
- R11: While no event is open, no hit word is read, no beat is offered and no road word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_has_eoe | input | 12 | Per hit queue: at least one end-of-event word is buffered |
| in_valid | input | 12 | Per hit lane: head word present |
| in_data | input | 192 | Hit lane head words, 16 bits per lane |
| in_eoe | input | 12 | Per hit lane: head word is an end-of-event word |
| in_ready | output | 12 | Per hit lane: head word consumed this cycle |
| bc_valid | output | 1 | Broadcast beat offered to the engines |
| bc_data | output | 192 | Broadcast beat, one 16-bit slot per lane (zero when the lane is closed) |
| bc_lane | output | 12 | Lanes still open in this event |
| bc_eoe | output | 12 | Per open lane: slot carries its end-of-event word |
| eng_ready | input | 4 | Per engine: ready to take a beat |
| rin_valid | input | 16 | Per road link: engine offers a road word |
| rin_data | input | 256 | Road words from the engines, 16 bits per link |
| rin_eoe | input | 16 | Per road link: offered word is an end-of-event word |
| rin_ready | output | 16 | Per road link: word consumed when valid |
| rout_valid | output | 16 | Per road link: word delivered downstream |
| rout_data | output | 256 | Delivered road words, 16 bits per link |
| rout_eoe | output | 16 | Per road link: delivered word is an end-of-event word |
| hold | input | 16 | Per road link: downstream buffer half full |
| evt_busy | output | 1 | An event is open |
| evt_done | output | 1 | One-cycle event completion pulse |
| evt_count | output | 16 | Number of completed events |

## Verification
The bench opens the first event with one hit queue still missing its end-of-event word and confirms that nothing moves. A design that checked any single queue, instead of all of them, would start early and mix events. It stalls a single engine and briefly removes one lane's head word. A broadcast that ignored either condition would give the engines different hit streams or read a lane that has no data. It refills the hit queues and one road link with next-event words before the current event ends, holds one link, and withholds one link's end-of-event word. A design with a faulty close mask would let the next event leak into the current one. A design with faulty hold gating would drop or duplicate a road. A design with a faulty completion check would pulse `evt_done` while a link is still held.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/evt_hit_bcast.sv
// Lockstep read of all open hit lanes into one broadcast beat.
module evt_hit_bcast #(
  parameter int N_IN  = 12,
  parameter int N_ENG = 4,
  parameter int HIT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  clr,
  input  logic [N_IN-1:0]       in_valid,
  input  logic [N_IN*HIT_W-1:0] in_data,
  input  logic [N_IN-1:0]       in_eoe,
  output logic [N_IN-1:0]       in_ready,
  input  logic [N_ENG-1:0]      eng_ready,
  output logic                  bc_valid,
  output logic [N_IN*HIT_W-1:0] bc_data,
  output logic [N_IN-1:0]       bc_lane,
  output logic [N_IN-1:0]       bc_eoe,
  output logic                  all_done
);
  logic [N_IN-1:0] lane_closed_q;
  logic [N_IN-1:0] lane_open;
  logic [N_IN-1:0] lane_ok;
  logic            beat_go;

  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    assign lane_open[g] = ~lane_closed_q[g];
    assign lane_ok[g]   = in_valid[g] | lane_closed_q[g];
    assign in_ready[g]  = beat_go & lane_open[g];
    assign bc_lane[g]   = run & lane_open[g];
    assign bc_eoe[g]    = run & lane_open[g] & in_eoe[g];
    assign bc_data[g*HIT_W +: HIT_W] = (run & lane_open[g]) ? in_data[g*HIT_W +: HIT_W] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      lane_closed_q[g] <= 1'b0;
      else if (clr)                    lane_closed_q[g] <= 1'b0;
      else if (in_ready[g] & in_eoe[g]) lane_closed_q[g] <= 1'b1;
    end
  end

  assign bc_valid = run & (&lane_ok) & (|lane_open);
  assign beat_go  = bc_valid & (&eng_ready);
  assign all_done = &lane_closed_q;
endmodule

// File: rtl/evt_road_gate.sv
// Per-link road pass-through with hold gating and close mask.
module evt_road_gate #(
  parameter int N_ROAD = 16,
  parameter int ROAD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     open_evt,
  input  logic                     clr,
  input  logic [N_ROAD-1:0]        hold,
  input  logic [N_ROAD-1:0]        rin_valid,
  input  logic [N_ROAD*ROAD_W-1:0] rin_data,
  input  logic [N_ROAD-1:0]        rin_eoe,
  output logic [N_ROAD-1:0]        rin_ready,
  output logic [N_ROAD-1:0]        rout_valid,
  output logic [N_ROAD*ROAD_W-1:0] rout_data,
  output logic [N_ROAD-1:0]        rout_eoe,
  output logic                     all_done
);
  logic [N_ROAD-1:0] link_closed_q;
  logic [N_ROAD-1:0] link_pass;

  for (genvar g = 0; g < N_ROAD; g++) begin : g_link
    assign link_pass[g]  = open_evt & ~hold[g] & ~link_closed_q[g];
    assign rin_ready[g]  = link_pass[g];
    assign rout_valid[g] = link_pass[g] & rin_valid[g];
    assign rout_eoe[g]   = rout_valid[g] & rin_eoe[g];
    assign rout_data[g*ROAD_W +: ROAD_W] = rout_valid[g] ? rin_data[g*ROAD_W +: ROAD_W] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           link_closed_q[g] <= 1'b0;
      else if (clr)         link_closed_q[g] <= 1'b0;
      else if (rout_eoe[g]) link_closed_q[g] <= 1'b1;
    end
  end

  assign all_done = &link_closed_q;
endmodule

// File: rtl/evt_seq_fsm.sv
// Event open/close sequencing and completion counter.
module evt_seq_fsm
  import evt_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             hits_closed,
  input  logic             roads_closed,
  output logic             run,
  output logic             clr,
  output logic             evt_done,
  output logic [CNT_W-1:0] evt_count
);
  seq_state_e state_q, state_d;
  logic       finish;

  assign finish = (state_q == SQ_RUN) & hits_closed & roads_closed;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (start_ok) state_d = SQ_RUN;
      SQ_RUN:  if (finish)   state_d = SQ_DONE;
      SQ_DONE:               state_d = SQ_IDLE;
      default:               state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      evt_count <= '0;
    end else begin
      state_q <= state_d;
      if (finish) evt_count <= evt_count + 1'b1;
    end
  end

  assign run      = (state_q == SQ_RUN);
  assign clr      = (state_q == SQ_DONE);
  assign evt_done = clr;
endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl #(
  parameter int N_IN   = 12,
  parameter int N_ENG  = 4,
  parameter int N_ROAD = 16,
  parameter int HIT_W  = 16,
  parameter int ROAD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          fifo_has_eoe,
  input  logic [N_IN-1:0]          in_valid,
  input  logic [N_IN*HIT_W-1:0]    in_data,
  input  logic [N_IN-1:0]          in_eoe,
  output logic [N_IN-1:0]          in_ready,
  output logic                     bc_valid,
  output logic [N_IN*HIT_W-1:0]    bc_data,
  output logic [N_IN-1:0]          bc_lane,
  output logic [N_IN-1:0]          bc_eoe,
  input  logic [N_ENG-1:0]         eng_ready,
  input  logic [N_ROAD-1:0]        rin_valid,
  input  logic [N_ROAD*ROAD_W-1:0] rin_data,
  input  logic [N_ROAD-1:0]        rin_eoe,
  output logic [N_ROAD-1:0]        rin_ready,
  output logic [N_ROAD-1:0]        rout_valid,
  output logic [N_ROAD*ROAD_W-1:0] rout_data,
  output logic [N_ROAD-1:0]        rout_eoe,
  input  logic [N_ROAD-1:0]        hold,
  output logic                     evt_busy,
  output logic                     evt_done,
  output logic [CNT_W-1:0]         evt_count
);
  logic run, clr, hits_closed, roads_closed;

  evt_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_ok     (&fifo_has_eoe),
    .hits_closed  (hits_closed),
    .roads_closed (roads_closed),
    .run          (run),
    .clr          (clr),
    .evt_done     (evt_done),
    .evt_count    (evt_count)
  );

  evt_hit_bcast #(.N_IN(N_IN), .N_ENG(N_ENG), .HIT_W(HIT_W)) u_bcast (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_eoe    (in_eoe),
    .in_ready  (in_ready),
    .eng_ready (eng_ready),
    .bc_valid  (bc_valid),
    .bc_data   (bc_data),
    .bc_lane   (bc_lane),
    .bc_eoe    (bc_eoe),
    .all_done  (hits_closed)
  );

  evt_road_gate #(.N_ROAD(N_ROAD), .ROAD_W(ROAD_W)) u_roads (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_evt   (run),
    .clr        (clr),
    .hold       (hold),
    .rin_valid  (rin_valid),
    .rin_data   (rin_data),
    .rin_eoe    (rin_eoe),
    .rin_ready  (rin_ready),
    .rout_valid (rout_valid),
    .rout_data  (rout_data),
    .rout_eoe   (rout_eoe),
    .all_done   (roads_closed)
  );

  assign evt_busy = run;
endmodule

// File: rtl/evt_seq_ctrl_chk.sv
module evt_seq_ctrl_chk #(
  parameter int N_IN   = 12,
  parameter int N_ENG  = 4,
  parameter int N_ROAD = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IN-1:0]   fifo_has_eoe,
  input logic [N_IN-1:0]   in_ready,
  input logic              bc_valid,
  input logic [N_ENG-1:0]  eng_ready,
  input logic [N_ROAD-1:0] rin_valid,
  input logic [N_ROAD-1:0] rin_ready,
  input logic [N_ROAD-1:0] rout_valid,
  input logic [N_ROAD-1:0] hold,
  input logic              evt_busy,
  input logic              evt_done,
  input logic [CNT_W-1:0]  evt_count
);
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_busy) |-> $past(&fifo_has_eoe));

  // R4
  stall_blocks_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> (bc_valid && (&eng_ready)));

  // R6
  road_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rout_valid) |-> ((rout_valid & ~(rin_valid & rin_ready)) == '0));

  // R7
  hold_blocks_road_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hold) |-> ((hold & (rout_valid | rin_ready)) == '0));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (evt_count == $past(evt_count) + 1'b1));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_busy |-> (in_ready == '0 && rin_ready == '0 && !bc_valid));
endmodule

bind evt_seq_ctrl evt_seq_ctrl_chk #(
  .N_IN(N_IN), .N_ENG(N_ENG), .N_ROAD(N_ROAD), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/evt_seq_ctrl_tb_top.sv
module evt_seq_ctrl_tb_top;
  localparam int N_IN = 12, N_ENG = 4, N_ROAD = 16, HIT_W = 16, ROAD_W = 16, CNT_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic [N_IN-1:0]          fifo_has_eoe, in_valid, in_eoe, in_ready, bc_lane, bc_eoe;
  logic [N_IN*HIT_W-1:0]    in_data, bc_data;
  logic                     bc_valid, evt_busy, evt_done;
  logic [N_ENG-1:0]         eng_ready;
  logic [N_ROAD-1:0]        rin_valid, rin_eoe, rin_ready, rout_valid, rout_eoe, hold;
  logic [N_ROAD*ROAD_W-1:0] rin_data, rout_data;
  logic [CNT_W-1:0]         evt_count;

  evt_seq_ctrl dut_i (.*);

  // queue models: word at position p of lane i is {i, p}
  int lane_wr[N_IN], lane_rd[N_IN], lane_ewr[N_IN], lane_erd[N_IN];
  logic [63:0] lane_mem[N_IN];
  int road_wr[N_ROAD], road_rd[N_ROAD];
  logic [63:0] road_mem[N_ROAD];
  logic [N_IN-1:0] gap;
  logic [N_IN-1:0] lane_closed_tb;
  logic [N_ROAD-1:0] road_closed_tb;
  int checks = 0, errors = 0, ev_seen = 0, beats = 0, last_beats = 0;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      in_valid[i]     = (lane_rd[i] < lane_wr[i]) && !gap[i];
      in_eoe[i]       = lane_mem[i][lane_rd[i][5:0]];
      in_data[i*HIT_W +: HIT_W] = {4'(i), 12'(lane_rd[i])};
      fifo_has_eoe[i] = lane_ewr[i] > lane_erd[i];
    end
    for (int l = 0; l < N_ROAD; l++) begin
      rin_valid[l] = road_rd[l] < road_wr[l];
      rin_eoe[l]   = road_mem[l][road_rd[l][5:0]];
      rin_data[l*ROAD_W +: ROAD_W] = {4'(l), 12'(road_rd[l])};
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [N_IN-1:0] nl;
    logic [N_ROAD-1:0] nr;
    nl = lane_closed_tb;
    nr = road_closed_tb;
    for (int i = 0; i < N_IN; i++)
      if (in_valid[i] && in_ready[i]) begin
        lane_rd[i] <= lane_rd[i] + 1;
        if (in_eoe[i]) begin
          lane_erd[i] <= lane_erd[i] + 1;
          nl[i] = 1'b1;
        end
      end
    for (int l = 0; l < N_ROAD; l++)
      if (rin_valid[l] && rin_ready[l]) begin
        road_rd[l] <= road_rd[l] + 1;
        if (rin_eoe[l]) nr[l] = 1'b1;
      end
    lane_closed_tb <= evt_done ? '0 : nl;
    road_closed_tb <= evt_done ? '0 : nr;
    if (evt_done) begin
      last_beats <= beats;
      beats <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (bc_valid && (&eng_ready)) begin
        beats++;
        for (int i = 0; i < N_IN; i++)
          if (bc_lane[i])
            chk(bc_data[i*HIT_W +: HIT_W] == {4'(i), 12'(lane_rd[i])}, "R3 beat slot",
                bc_data[i*HIT_W +: HIT_W], {4'(i), 12'(lane_rd[i])});
      end
      for (int i = 0; i < N_IN; i++)
        if (in_ready[i]) chk(!lane_closed_tb[i], "R5 closed lane read", 1, 0);
      for (int l = 0; l < N_ROAD; l++) begin
        if (rout_valid[l])
          chk(rout_data[l*ROAD_W +: ROAD_W] == {4'(l), 12'(road_rd[l])}, "R6 road order",
              rout_data[l*ROAD_W +: ROAD_W], {4'(l), 12'(road_rd[l])});
        if (hold[l]) chk(!rout_valid[l] && !rin_ready[l], "R7 held link moved", 1, 0);
        if (rin_ready[l] && rin_valid[l]) chk(!road_closed_tb[l], "R8 closed link accepted", 1, 0);
      end
      if (evt_done) begin
        chk((&lane_closed_tb) && (&road_closed_tb), "R9 early completion",
            {lane_closed_tb, road_closed_tb}, {28{1'b1}});
        chk(evt_count == CNT_W'(ev_seen + 1), "R9 count", evt_count, ev_seen + 1);
        ev_seen++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_lane(input int i, input int n);
    for (int k = 0; k < n; k++) begin
      lane_mem[i][lane_wr[i][5:0]] = 1'b0;
      lane_wr[i]++;
    end
    lane_mem[i][lane_wr[i][5:0]] = 1'b1;
    lane_wr[i]++;
    lane_ewr[i]++;
  endtask

  task automatic push_roads(input int l, input int n, input bit with_eoe);
    for (int k = 0; k < n; k++) begin
      road_mem[l][road_wr[l][5:0]] = 1'b0;
      road_wr[l]++;
    end
    if (with_eoe) begin
      road_mem[l][road_wr[l][5:0]] = 1'b1;
      road_wr[l]++;
    end
  endtask

  task automatic wait_events(input int target, input int limit);
    for (int k = 0; k < limit && ev_seen < target; k++) @(negedge clk);
    chk(ev_seen >= target, "R9 completion reached", ev_seen, target);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!evt_busy && !evt_done && !bc_valid, "R1 idle flags", {evt_busy, evt_done, bc_valid}, 0);
    chk(in_ready == '0 && rin_ready == '0, "R1 readies", {in_ready, rin_ready}, 0);
    chk(evt_count == '0, "R1 count", evt_count, 0);
  endtask

  task automatic t_start_gate();
    tick();
    for (int l = 0; l < N_ROAD; l++) push_roads(l, l % 3, l != 9);
    push_roads(3, 2, 1'b1);
    hold[5] = 1'b1;
    eng_ready[1] = 1'b0;
    for (int i = 0; i < N_IN - 1; i++) load_lane(i, i % 5);
    repeat (8) @(negedge clk);
    chk(!evt_busy, "R2 start without all queues", evt_busy, 0);
    chk(in_ready == '0 && !bc_valid, "R11 no hit read idle", in_ready, 0);
    chk(rin_ready == '0 && rout_valid == '0, "R11 no road idle", rin_ready, 0);
    tick();
    load_lane(N_IN - 1, (N_IN - 1) % 5);
    @(negedge clk);
    chk(!evt_busy, "R2 opens one clock later", evt_busy, 0);
    @(negedge clk);
    chk(evt_busy, "R2 open", evt_busy, 1);
  endtask

  task automatic t_stall_gap();
    chk(bc_valid, "R3 beat offered", bc_valid, 1);
    for (int k = 0; k < 4; k++) begin
      chk(in_ready == '0, "R4 engine stall", in_ready, 0);
      @(negedge clk);
    end
    tick();
    gap[7] = 1'b1;
    eng_ready[1] = 1'b1;
    @(negedge clk);
    chk(!bc_valid && in_ready == '0, "R3 lane empty stalls beat", bc_valid, 0);
    tick();
    gap[7] = 1'b0;
    for (int k = 0; k < 40 && beats < 5; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(beats == 5, "R3 beat count event 1", beats, 5);
    tick();
    for (int i = 0; i < N_IN; i++) load_lane(i, (i * 3) % 4);
    repeat (5) begin
      @(negedge clk);
      chk(in_ready == '0 && !bc_valid, "R5 next event words wait", in_ready, 0);
    end
  endtask

  task automatic t_hold_finish();
    repeat (10) @(negedge clk);
    chk(ev_seen == 0 && evt_busy, "R9 no completion while link open", ev_seen, 0);
    chk(road_rd[5] == 0, "R7 held link not consumed", road_rd[5], 0);
    tick();
    hold[5] = 1'b0;
    push_roads(9, 0, 1'b1);
    wait_events(1, 40);
    chk(last_beats == 5, "R3 beats recorded event 1", last_beats, 5);
    chk(road_rd[5] == 3, "R7 words after release", road_rd[5], 3);
    chk(road_rd[3] == 1, "R8 next event roads held back", road_rd[3], 1);
  endtask

  task automatic t_next_event();
    tick();
    for (int l = 0; l < N_ROAD; l++)
      if (l != 3) push_roads(l, (l + 1) % 2, 1'b1);
    wait_events(2, 80);
    chk(evt_count == 16'd2, "R10 second event count", evt_count, 2);
    chk(last_beats == 4, "R10 lanes reopened", last_beats, 4);
    chk(road_rd[3] == 4, "R10 link reopened", road_rd[3], 4);
    chk(road_rd[5] == 4, "R6 link 5 total", road_rd[5], 4);
  endtask

  initial begin
    for (int i = 0; i < N_IN; i++) begin
      lane_wr[i] = 0; lane_rd[i] = 0; lane_ewr[i] = 0; lane_erd[i] = 0; lane_mem[i] = '0;
    end
    for (int l = 0; l < N_ROAD; l++) begin
      road_wr[l] = 0; road_rd[l] = 0; road_mem[l] = '0;
    end
    gap = '0; hold = '0; eng_ready = '1;
    lane_closed_tb = '0; road_closed_tb = '0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_start_gate();
    t_stall_gap();
    t_hold_finish();
    t_next_event();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule